// File: doc/BRIEF.md
# Serial-Loaded Switch-Array Controller

This block drives the on/off enables of a row of analog channels, 32 by default. In individual mode a serial bit stream enters a shift register, one bit per shift strobe. A latch stage then passes the register to the channel enables. The latch is open while the latch-enable pin is low and holds while that pin is high. The last register stage is brought out as a serial output, so several controllers can be chained into one long register.

In bank mode the shift register has no say over the channels. The latch-enable pin becomes a plain enable, and the data pin picks which half of the array conducts: the even-numbered channels or the odd-numbered ones. A low standby input turns every channel off in either mode. After standby is released, the outputs stay off for a programmable number of clock cycles, which models the wake-up time of the analog side. A clear input empties the shift register and the latch, and in individual mode it forces the outputs off at once.

All state sits in the `clk` domain. The external shift clock is represented by `shift_stb`, a strobe that lasts one cycle per rising edge of the shift clock.

Top module: `swa_ctrl`

## Requirements
- R1: After `rst_n` is released, every bit of `chan_on` is 0 until `standby_n` has been high for `WAKE_CYCLES` consecutive clock edges.
- R2: On each clock edge with `shift_stb`=1 and `clr`=0, stage 0 loads `din_sel` and stage i loads stage i-1. `ser_out` always equals the last stage, N-1.
- R3: In individual mode (`mode_indiv`=1) with `le_en`=0, `clr`=0 and the block awake, `chan_on[i]` equals shift stage i in the same cycle. A stored 1 means on.
- R4: While `le_en`=1 in individual mode, `chan_on` shows the register content present after the last clock edge at which `le_en` was 0. Shifting with `le_en`=1 leaves `chan_on` unchanged.
- R5: In individual mode, `clr`=1 forces `chan_on` to 0 in the same cycle, whatever the other inputs are. The shift register and latch are all zeros after the next edge, so `ser_out` reads 0.
- R6: In bank mode (`mode_indiv`=0) with `le_en`=0, all channels are off.
- R7: In bank mode with `le_en`=1 and the block awake, `din_sel`=1 turns on the even-indexed channels (bit 0, 2, …) and turns off the odd ones. `din_sel`=0 does the reverse. Exactly N/2 channels are on.
- R8: In bank mode, `chan_on` does not depend on the shift register contents or on `clr`.
- R9: `standby_n`=0 forces `chan_on` to 0 in any mode. Any low cycle on `standby_n` restarts the full wake-up count.
- R10: When `ser_out` of one instance feeds `din_sel` of a second instance, the pair acts as one 2N-stage register. Bit k of the serial stream reaches the second instance after N more strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Low puts the block in standby and turns all channels off |
| mode_indiv | input | 1 | 1 selects individual mode, 0 selects bank mode |
| clr | input | 1 | Clears the register and latch; forces outputs off in individual mode |
| shift_stb | input | 1 | One-cycle strobe that advances the shift register |
| din_sel | input | 1 | Serial data in individual mode; group select in bank mode |
| le_en | input | 1 | Latch hold (high) in individual mode; enable in bank mode |
| ser_out | output | 1 | Last shift stage, used for chaining |
| chan_on | output | N | Per-channel enable, 1 = conducting |

## Verification
The bench chains two instances and runs directed and random stimulus. It aims at these corner cases:
- A shift strobe in the same cycle that `le_en` rises. A design that latched the post-shift value would show the new bit on the channels.
- A clear pulse while the latch is holding. Leaving the latch content alive would bring stale channels back once `clr` drops.
- A standby drop partway through the wake-up count. A counter that resumes instead of restarting would enable the outputs too early.
- Bank-mode cycles with a full register and `clr` high. A select wired to the wrong parity, or an output gated by `clr` in bank mode, shows up as a mismatch on `chan_on`.

// File: rtl/swa_pkg.sv
package swa_pkg;
    typedef enum logic {
        MODE_BANK  = 1'b0,
        MODE_INDIV = 1'b1
    } swa_mode_e;
endpackage

// File: rtl/swa_shift_latch.sv
module swa_shift_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_stb,
    input  logic         ser_in,
    input  logic         latch_hold,
    output logic [N-1:0] view,
    output logic         ser_out
);
    typedef struct packed {
        logic [N-1:0] sh;
        logic [N-1:0] lat;
    } sl_t;

    sl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (shift_stb) st_d.sh = {st_q.sh[N-2:0], ser_in};
            if (!latch_hold) st_d.lat = st_d.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign view    = latch_hold ? st_q.lat : st_q.sh;
    assign ser_out = st_q.sh[N-1];

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && !clr) |=> (ser_out == $past(st_q.sh[N-2])));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_hold && !clr) |=> $stable(st_q.lat));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == '0 && !ser_out));
endmodule

// File: rtl/swa_wake.sv
module swa_wake #(
    parameter int WAKE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_n,
    output logic ready
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } wk_t;

    wk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!standby_n) begin
            st_d = '0;
        end else if (!st_q.rdy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.rdy = (st_q.cnt == CW'(WAKE_CYCLES - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.rdy;

    // R9
    standby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> !ready);

    // R1
    wake_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(st_q.cnt) == CW'(WAKE_CYCLES - 1)));
endmodule

// File: rtl/swa_chan_mux.sv
module swa_chan_mux #(
    parameter int N = 32
) (
    input  logic                 active,
    input  swa_pkg::swa_mode_e   mode,
    input  logic                 clr,
    input  logic                 le_en,
    input  logic                 din_sel,
    input  logic [N-1:0]         view,
    output logic [N-1:0]         chan_on
);
    logic [N-1:0] bank_pat;

    for (genvar i = 0; i < N; i++) begin : g_bank
        if (i % 2 == 0) begin : g_even
            assign bank_pat[i] = din_sel;
        end else begin : g_odd
            assign bank_pat[i] = !din_sel;
        end
    end

    always_comb begin
        chan_on = '0;
        if (active) begin
            if (mode == swa_pkg::MODE_INDIV) begin
                if (!clr) chan_on = view;
            end else if (le_en) begin
                chan_on = bank_pat;
            end
        end
    end
endmodule

// File: rtl/swa_ctrl.sv
module swa_ctrl #(
    parameter int N           = 32,
    parameter int WAKE_CYCLES = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby_n,
    input  logic         mode_indiv,
    input  logic         clr,
    input  logic         shift_stb,
    input  logic         din_sel,
    input  logic         le_en,
    output logic         ser_out,
    output logic [N-1:0] chan_on
);
    localparam int HALF = N / 2;

    swa_pkg::swa_mode_e mode;
    logic [N-1:0]       view;
    logic               ready;
    logic               active;

    assign mode   = swa_pkg::swa_mode_e'(mode_indiv);
    assign active = ready && standby_n;

    swa_shift_latch #(.N(N)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .shift_stb  (shift_stb),
        .ser_in     (din_sel),
        .latch_hold (le_en),
        .view       (view),
        .ser_out    (ser_out)
    );

    swa_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_n (standby_n),
        .ready     (ready)
    );

    swa_chan_mux #(.N(N)) u_mux (
        .active  (active),
        .mode    (mode),
        .clr     (clr),
        .le_en   (le_en),
        .din_sel (din_sel),
        .view    (view),
        .chan_on (chan_on)
    );

    // R9
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |-> (chan_on == '0));

    // R5
    clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_indiv && clr) |-> (chan_on == '0));

    // R6
    bank_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_indiv && !le_en) |-> (chan_on == '0));

    // R7
    bank_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_indiv && le_en && active) |-> ($countones(chan_on) == HALF));
endmodule

// File: tb/test_swa_ctrl.sv
module test_swa_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_n = 1'b0, mode_indiv = 1'b1, clr = 1'b0;
    logic shift_stb = 1'b0, din_sel = 1'b0, le_en = 1'b0;
    logic ser0, ser1;
    logic [N-1:0] ch0, ch1;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [2*N-1:0] m_sh = '0, m_lat = '0;
    int m_cnt = 0;
    bit m_rdy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swa_ctrl #(.N(N), .WAKE_CYCLES(W)) i_swa_ctrl (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .mode_indiv(mode_indiv),
        .clr(clr), .shift_stb(shift_stb), .din_sel(din_sel), .le_en(le_en),
        .ser_out(ser0), .chan_on(ch0));

    swa_ctrl #(.N(N), .WAKE_CYCLES(W)) i_swa_ctrl_tail (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .mode_indiv(mode_indiv),
        .clr(clr), .shift_stb(shift_stb), .din_sel(ser0), .le_en(le_en),
        .ser_out(ser1), .chan_on(ch1));

    function automatic logic [N-1:0] exp_chan(input logic [N-1:0] sh, input logic [N-1:0] lat,
                                              input logic sel);
        logic [N-1:0] r = '0;
        if (!standby_n || !m_rdy) return '0;
        if (mode_indiv) return clr ? '0 : (le_en ? lat : sh);
        if (!le_en) return '0;
        for (int i = 0; i < N; i++) r[i] = (i % 2 == 0) ? sel : !sel;
        return r;
    endfunction

    function automatic string tag_of();
        if (!m_rdy) return "R1";
        if (!standby_n) return "R9";
        if (!mode_indiv) return clr ? "R8" : (le_en ? "R7" : "R6");
        if (clr) return "R5";
        return le_en ? "R4" : "R3";
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle();
        logic [2*N-1:0] nsh;
        @(negedge clk);
        check(tag_of(), ch0, exp_chan(m_sh[N-1:0], m_lat[N-1:0], din_sel));
        check((mode_indiv || !le_en) ? tag_of() : "R10", ch1,
              exp_chan(m_sh[2*N-1:N], m_lat[2*N-1:N], m_sh[N-1]));
        check("R2", {{(N-1){1'b0}}, ser0}, {{(N-1){1'b0}}, m_sh[N-1]});
        check("R10", {{(N-1){1'b0}}, ser1}, {{(N-1){1'b0}}, m_sh[2*N-1]});
        @(posedge clk);
        if (rst_n) begin
            if (clr) begin
                m_sh = '0; m_lat = '0;
            end else begin
                nsh = shift_stb ? {m_sh[2*N-2:0], din_sel} : m_sh;
                m_sh = nsh;
                if (!le_en) m_lat = nsh;
            end
            if (!standby_n) begin
                m_cnt = 0; m_rdy = 1'b0;
            end else if (!m_rdy) begin
                m_cnt++; m_rdy = (m_cnt == W);
            end
        end
        #1;
    endtask

    task automatic drive(input logic s, input logic m, input logic c, input logic st,
                         input logic d, input logic l);
        standby_n = s; mode_indiv = m; clr = c; shift_stb = st; din_sel = d; le_en = l;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [2*N-1:0] pat;
        void'($urandom(32'h5EED_1234));
        // R1: reset state and standby default
        cycle(); cycle();
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < 4; i++) cycle();
        drive(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < W + 3; i++) cycle();
        // R3 / R10: shift 64 bits with the latch open
        pat = 64'hA5F0_0FF0_1234_8001;
        for (int i = 2*N - 1; i >= 0; i--) begin
            drive(1, 1, 0, 1, pat[i], 0);
            cycle();
        end
        // R4: strobe on the same edge the latch closes, then keep shifting
        drive(1, 1, 0, 1, 1, 1); cycle();
        for (int i = 0; i < 10; i++) begin drive(1, 1, 0, 1, i[0], 1); cycle(); end
        drive(1, 1, 0, 0, 0, 1); cycle();
        // R5: clear during hold, then reopen
        drive(1, 1, 1, 1, 1, 1); cycle();
        drive(1, 1, 0, 0, 0, 1); cycle();
        drive(1, 1, 0, 0, 0, 0); cycle();
        // fill again for bank-mode checks
        for (int i = 0; i < 2*N; i++) begin drive(1, 1, 0, 1, 1, 0); cycle(); end
        // R6 R7 R8: bank mode with full register and clr toggling
        for (int k = 0; k < 8; k++) begin
            drive(1, 0, k[2], 0, k[0], k[1]); cycle();
        end
        // R9: standby drop partway through wake-up
        drive(0, 0, 0, 0, 1, 1); cycle();
        drive(1, 0, 0, 0, 1, 1);
        for (int i = 0; i < W / 2; i++) cycle();
        drive(0, 0, 0, 0, 1, 1); cycle();
        drive(1, 0, 0, 0, 1, 1);
        for (int i = 0; i < W + 2; i++) cycle();
        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic m;
            m = ($urandom % 50 == 0) ? !mode_indiv : mode_indiv;
            drive(($urandom % 100) != 0, m, ($urandom % 32) == 0, $urandom % 2 == 0,
                  1'($urandom), ($urandom % 10) < 3);
            cycle();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule